// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This block decides when an analog-to-digital converter runs its self-calibration, and it reports the calibration status. All inputs are sampled on the converter sample clock. After reset, which stands for power-up, the block waits a selectable number of cycles and then starts one calibration by itself. After that it accepts on-command calibration requests. A request counts only as a qualified pulse pattern on a single input: a long enough low run followed by a long enough high run. A single edge does not start anything.

Each calibration begins with a one-cycle start pulse to the calibration engine. A busy output stays high until the engine returns its done handshake. A power-down input holds the block idle and cancels any calibration that is pending or running. An extended-control flag removes the choice of the long power-up delay. The analog trimming is outside this block.

Top module: `cal_sequencer`

## Requirements
- R1: While reset is low, `cal_start_o` and `cal_busy_o` are low.
- R2: With `dly_sel_i` = 0, the power-up calibration start pulse appears after the SHORT_DLY-th rising clock edge following reset release.
- R3: With `dly_sel_i` = 1 and `ext_ctrl_i` = 0, the power-up start pulse appears after the LONG_DLY-th edge following reset release.
- R4: With `ext_ctrl_i` = 1, the short delay is used whatever the value of `dly_sel_i`.
- R5: In idle, `cal_req_i` sampled low on at least QUAL_CYCLES consecutive edges and then high on QUAL_CYCLES consecutive edges gives a start pulse right after the edge that samples the final qualifying high.
- R6: A low run shorter than QUAL_CYCLES, followed by a high, starts nothing, however long the high run lasts.
- R7: A high run shorter than QUAL_CYCLES discards the low phase already gathered. The next low sample begins a new low count.
- R8: `cal_start_o` is exactly one cycle wide, and `cal_busy_o` rises in the same cycle as it.
- R9: `cal_busy_o` stays high until `cal_done_i` is sampled high, and it falls in the cycle after that edge.
- R10: `cal_req_i` activity during busy is ignored. The low-phase count starts from zero only after busy falls.
- R11: The edge after `pwr_dn_i` is sampled high leaves `cal_start_o` and `cal_busy_o` low. Any pending power-up calibration or partial request pattern is discarded.
- R12: Once power-down has been released, the power-up calibration does not repeat until the next reset. On-command requests work again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter sample clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| cal_req_i | input | 1 | Calibration request pattern input |
| dly_sel_i | input | 1 | Power-up delay select: 0 short, 1 long |
| ext_ctrl_i | input | 1 | Extended control active; forces the short delay |
| pwr_dn_i | input | 1 | Power-down; holds the block idle |
| cal_done_i | input | 1 | Done handshake from the calibration engine |
| cal_start_o | output | 1 | One-cycle start pulse to the calibration engine |
| cal_busy_o | output | 1 | High while a calibration runs |

## Verification
The assertions assume that `cal_done_i` is a handshake that matters only while busy is high. They also assume that reset is held for at least one clock edge, so that `$past` of busy has a defined value. The stimulus sends one done pulse per calibration, always during busy. It changes every input only at the falling clock edge, so the sequencer sees each request run length exactly as it was driven. The power-down cases put `pwr_dn_i` during the power-up wait, in the middle of a request pattern and during busy, which exercises the forced-idle path from each state.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
    typedef enum logic [1:0] {
        ST_PWRUP = 2'd0,
        ST_IDLE  = 2'd1,
        ST_BUSY  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/cal_req_qualifier.sv
// Detects a low run of QUAL_CYCLES samples followed by a high run of
// QUAL_CYCLES samples. Cleared whenever en_i is low. QUAL_CYCLES >= 2.
module cal_req_qualifier #(
    parameter int QUAL_CYCLES = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic req_i,
    output logic fire_o
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] QMAX = CW'(QUAL_CYCLES);
    localparam logic [CW-1:0] QLAST = CW'(QUAL_CYCLES - 1);

    typedef struct packed {
        logic          hi_phase;
        logic [CW-1:0] lo_cnt;
        logic [CW-1:0] hi_cnt;
    } qual_t;

    qual_t q_q, q_d;
    logic  fire_d;

    always_comb begin
        q_d    = q_q;
        fire_d = 1'b0;
        if (!en_i) begin
            q_d = '0;
        end else if (!q_q.hi_phase) begin
            if (!req_i) begin
                if (q_q.lo_cnt < QMAX) q_d.lo_cnt = q_q.lo_cnt + 1'b1;
            end else if (q_q.lo_cnt == QMAX) begin
                q_d.hi_phase = 1'b1;
                q_d.hi_cnt   = CW'(1);
            end else begin
                q_d.lo_cnt = '0;
            end
        end else begin
            if (req_i) begin
                if (q_q.hi_cnt == QLAST) begin
                    fire_d = 1'b1;
                    q_d    = '0;
                end else begin
                    q_d.hi_cnt = q_q.hi_cnt + 1'b1;
                end
            end else begin
                // short high run: restart, this low sample counts as the first
                q_d.hi_phase = 1'b0;
                q_d.hi_cnt   = '0;
                q_d.lo_cnt   = CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign fire_o = fire_d;
endmodule

// File: rtl/cal_pu_timer.sv
// Counts cycles after power-up while run_i is high; expired_o marks the
// cycle whose following edge is the selected delay.
module cal_pu_timer #(
    parameter int SHORT_DLY = 65536,
    parameter int LONG_DLY  = 16777216
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic long_i,
    output logic expired_o
);
    localparam int TW = $clog2(LONG_DLY + 1);
    localparam logic [TW-1:0] SHORT_LAST = TW'(SHORT_DLY - 1);
    localparam logic [TW-1:0] LONG_LAST  = TW'(LONG_DLY - 1);

    logic [TW-1:0] cnt_q, cnt_d;
    logic [TW-1:0] last_d;

    always_comb begin
        last_d    = long_i ? LONG_LAST : SHORT_LAST;
        expired_o = (cnt_q >= last_d);
        cnt_d     = cnt_q;
        if (run_i && !expired_o) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
    import cal_seq_pkg::*;
#(
    parameter int QUAL_CYCLES = 80,
    parameter int SHORT_DLY   = 65536,
    parameter int LONG_DLY    = 16777216
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_req_i,
    input  logic dly_sel_i,
    input  logic ext_ctrl_i,
    input  logic pwr_dn_i,
    input  logic cal_done_i,
    output logic cal_start_o,
    output logic cal_busy_o
);
    typedef struct packed {
        seq_state_e state;
        logic       start;
    } seq_t;

    seq_t seq_q, seq_d;
    logic pu_run, pu_long, pu_expired;
    logic qual_en, qual_fire;

    assign pu_run  = (seq_q.state == ST_PWRUP) && !pwr_dn_i;
    assign pu_long = dly_sel_i && !ext_ctrl_i;
    assign qual_en = (seq_q.state == ST_IDLE) && !pwr_dn_i;

    cal_pu_timer #(
        .SHORT_DLY (SHORT_DLY),
        .LONG_DLY  (LONG_DLY)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (pu_run),
        .long_i    (pu_long),
        .expired_o (pu_expired)
    );

    cal_req_qualifier #(
        .QUAL_CYCLES (QUAL_CYCLES)
    ) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (qual_en),
        .req_i  (cal_req_i),
        .fire_o (qual_fire)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        if (pwr_dn_i) begin
            seq_d.state = ST_IDLE;
        end else begin
            unique case (seq_q.state)
                ST_PWRUP: if (pu_expired) begin
                    seq_d.state = ST_BUSY;
                    seq_d.start = 1'b1;
                end
                ST_IDLE: if (qual_fire) begin
                    seq_d.state = ST_BUSY;
                    seq_d.start = 1'b1;
                end
                ST_BUSY: if (cal_done_i) seq_d.state = ST_IDLE;
                default: seq_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_PWRUP;
            seq_q.start <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cal_start_o = seq_q.start;
    assign cal_busy_o  = (seq_q.state == ST_BUSY);
endmodule

// File: rtl/cal_sequencer_checker.sv
module cal_sequencer_checker (
    input logic clk,
    input logic rst_n,
    input logic pwr_dn_i,
    input logic cal_done_i,
    input logic cal_start_o,
    input logic cal_busy_o
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!cal_start_o && !cal_busy_o));

    p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start_o |=> !cal_start_o);

    p_start_with_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start_o |-> cal_busy_o);

    p_busy_rise_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_busy_o) |-> cal_start_o);

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy_o && !cal_done_i && !pwr_dn_i) |=> cal_busy_o);

    p_done_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy_o && cal_done_i) |=> !cal_busy_o);

    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy_o && $past(cal_busy_o)) |-> !cal_start_o);

    p_pd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn_i |=> (!cal_busy_o && !cal_start_o));
endmodule

bind cal_sequencer cal_sequencer_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_dn_i    (pwr_dn_i),
    .cal_done_i  (cal_done_i),
    .cal_start_o (cal_start_o),
    .cal_busy_o  (cal_busy_o)
);

// File: tb/cal_sequencer_bench.sv
module cal_sequencer_bench;
    localparam int QUAL  = 80;
    localparam int SHORT = 200;
    localparam int LONG  = 600;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, cal_req_i = 1'b1, dly_sel_i = 1'b0, ext_ctrl_i = 1'b0;
    logic pwr_dn_i = 1'b0, cal_done_i = 1'b0;
    logic cal_start_o, cal_busy_o;

    int    errors = 0;
    int    checks = 0;
    int    cyc    = 0;
    string cur_req = "R1";

    cal_sequencer #(.QUAL_CYCLES(QUAL), .SHORT_DLY(SHORT), .LONG_DLY(LONG)) u_cal_sequencer (
        .clk(clk), .rst_n(rst_n), .cal_req_i(cal_req_i), .dly_sel_i(dly_sel_i),
        .ext_ctrl_i(ext_ctrl_i), .pwr_dn_i(pwr_dn_i), .cal_done_i(cal_done_i),
        .cal_start_o(cal_start_o), .cal_busy_o(cal_busy_o));

    // behavioural reference: 0 waiting for power-up, 1 idle, 2 calibrating
    int m_mode = 0, m_age = 0, m_lows = 0, m_highs = 0;
    bit m_in_high = 0, m_start = 0, m_busy = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_age = 0; m_lows = 0; m_highs = 0;
            m_in_high = 0; m_start = 0; m_busy = 0;
        end else begin
            int  want;
            int  nmode;
            bit  go;
            go = 0;
            nmode = m_mode;
            if (pwr_dn_i) begin
                nmode = 1;
                m_lows = 0; m_highs = 0; m_in_high = 0;
            end else if (m_mode == 0) begin
                want = (dly_sel_i && !ext_ctrl_i) ? LONG : SHORT;
                if (m_age + 1 >= want) begin nmode = 2; go = 1; end
                else m_age = m_age + 1;
            end else if (m_mode == 1) begin
                if (!m_in_high) begin
                    if (!cal_req_i) m_lows = (m_lows < QUAL) ? m_lows + 1 : QUAL;
                    else if (m_lows >= QUAL) begin m_in_high = 1; m_highs = 1; end
                    else m_lows = 0;
                end else if (cal_req_i) begin
                    m_highs = m_highs + 1;
                    if (m_highs >= QUAL) begin
                        go = 1; nmode = 2;
                        m_lows = 0; m_highs = 0; m_in_high = 0;
                    end
                end else begin
                    m_in_high = 0; m_highs = 0; m_lows = 1;
                end
            end else begin
                if (cal_done_i) nmode = 1;
                m_lows = 0; m_highs = 0; m_in_high = 0;
            end
            m_mode  = nmode;
            m_start = go;
            m_busy  = (nmode == 2);
        end
    end

    // per-clock comparison against the reference
    always @(negedge clk) begin
        checks++;
        if (cal_start_o !== m_start || cal_busy_o !== m_busy) begin
            errors++;
            $display("FAIL %s: start/busy actual %0b/%0b expected %0b/%0b",
                     cur_req, cal_start_o, cal_busy_o, m_start, m_busy);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic sel, input logic ext);
        rst_n = 1'b0; dly_sel_i = sel; ext_ctrl_i = ext;
        cal_req_i = 1'b1; pwr_dn_i = 1'b0; cal_done_i = 1'b0;
        cur_req = "R1";
        repeat (3) step();
        check(!cal_start_o && !cal_busy_o, "R1 outputs in reset",
              {cal_start_o, cal_busy_o}, 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_start(input int limit, output int n);
        n = 0;
        while (!cal_start_o && n < limit) begin step(); n++; end
    endtask

    // engine model: busy for len cycles, then one done pulse
    task automatic engine(input int len);
        check(cal_busy_o == 1'b1, "R8 busy with start", cal_busy_o, 1);
        step();
        check(cal_start_o == 1'b0, "R8 start one cycle", cal_start_o, 0);
        repeat (len) step();
        check(cal_busy_o == 1'b1, "R9 busy until done", cal_busy_o, 1);
        cal_done_i = 1'b1;
        step();
        cal_done_i = 1'b0;
        check(cal_busy_o == 1'b0, "R9 busy falls after done", cal_busy_o, 0);
    endtask

    task automatic drive_req(input logic v, input int n, inout int starts);
        for (int i = 0; i < n; i++) begin
            cal_req_i = v;
            step();
            if (cal_start_o) starts++;
        end
    endtask

    initial begin
        int n;
        int s;
        step();

        // R2: short power-up delay
        do_reset(1'b0, 1'b0);
        cur_req = "R2";
        wait_start(1000, n);
        check(n == SHORT, "R2 short power-up latency", n, SHORT);
        engine(10);

        // R3: long delay
        do_reset(1'b1, 1'b0);
        cur_req = "R3";
        wait_start(1000, n);
        check(n == LONG, "R3 long power-up latency", n, LONG);
        engine(5);

        // R4: extended control forces short
        do_reset(1'b1, 1'b1);
        cur_req = "R4";
        wait_start(1000, n);
        check(n == SHORT, "R4 forced short latency", n, SHORT);
        engine(5);

        // R5: qualified pattern, start after the 80th high
        cur_req = "R5";
        s = 0;
        drive_req(1'b0, QUAL, s);
        n = 0;
        for (int i = 1; i <= QUAL + 20; i++) begin
            cal_req_i = 1'b1;
            step();
            if (cal_start_o) begin n = i; break; end
        end
        check(n == QUAL && s == 0, "R5 on-command latency", n, QUAL);
        engine(8);

        // R6: low run one short
        cur_req = "R6";
        s = 0;
        drive_req(1'b0, QUAL - 1, s);
        drive_req(1'b1, 150, s);
        check(s == 0, "R6 short low run ignored", s, 0);
        drive_req(1'b0, QUAL, s);
        drive_req(1'b1, QUAL, s);
        check(s == 1 && cal_start_o, "R6 full pattern after short low", s, 1);
        engine(6);

        // R7: short high run restarts the low phase
        cur_req = "R7";
        s = 0;
        drive_req(1'b0, QUAL, s);
        drive_req(1'b1, QUAL - 1, s);
        drive_req(1'b0, 10, s);
        drive_req(1'b1, 100, s);
        check(s == 0, "R7 old low phase discarded", s, 0);
        drive_req(1'b0, QUAL, s);
        drive_req(1'b1, QUAL - 1, s);
        drive_req(1'b0, QUAL, s);
        drive_req(1'b1, QUAL, s);
        check(s == 1 && cal_start_o, "R7 fresh pattern after short high", s, 1);
        engine(6);

        // R10: activity during busy ignored, low count restarts after busy
        cur_req = "R10";
        s = 0;
        drive_req(1'b0, QUAL, s);
        drive_req(1'b1, QUAL, s);
        check(s == 1, "R10 start before busy window", s, 1);
        s = 0;
        drive_req(1'b0, QUAL, s);
        drive_req(1'b1, QUAL, s);
        drive_req(1'b0, 50, s);
        check(s == 0 && cal_busy_o, "R10 pattern during busy ignored", s, 0);
        cal_done_i = 1'b1;
        step();
        cal_done_i = 1'b0;
        check(cal_busy_o == 1'b0, "R9 busy falls after done", cal_busy_o, 0);
        drive_req(1'b0, 30, s);
        drive_req(1'b1, 100, s);
        check(s == 0, "R10 low count restarts after busy", s, 0);

        // R11: power-down clears pattern, forces idle, blocks starts
        cur_req = "R11";
        s = 0;
        drive_req(1'b0, QUAL, s);
        pwr_dn_i = 1'b1;
        step();
        pwr_dn_i = 1'b0;
        drive_req(1'b1, 100, s);
        check(s == 0, "R11 pattern cleared by power-down", s, 0);
        pwr_dn_i = 1'b1;
        drive_req(1'b0, QUAL, s);
        drive_req(1'b1, QUAL, s);
        pwr_dn_i = 1'b0;
        check(s == 0, "R11 no start in power-down", s, 0);
        drive_req(1'b0, QUAL, s);
        drive_req(1'b1, QUAL, s);
        check(s == 1, "R11 start before power-down in busy", s, 1);
        step();
        pwr_dn_i = 1'b1;
        step();
        check(cal_busy_o == 1'b0, "R11 busy dropped by power-down", cal_busy_o, 0);
        pwr_dn_i = 1'b0;
        s = 0;
        drive_req(1'b1, 20, s);
        check(s == 0, "R11 no start after abort", s, 0);

        // R11/R12: power-down during the power-up wait, no repeat afterwards
        do_reset(1'b0, 1'b0);
        cur_req = "R11";
        pwr_dn_i = 1'b1;
        s = 0;
        drive_req(1'b1, 300, s);
        check(s == 0, "R11 power-up calibration cancelled", s, 0);
        pwr_dn_i = 1'b0;
        cur_req = "R12";
        drive_req(1'b1, 400, s);
        check(s == 0 && !cal_busy_o, "R12 no repeat of power-up calibration", s, 0);
        drive_req(1'b0, QUAL, s);
        drive_req(1'b1, QUAL, s);
        check(s == 1 && cal_start_o, "R12 on-command still works", s, 1);
        engine(4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule